// File: doc/BRIEF.md
# ADC Sequencer Sample Capture

This block is the digital side of a four-channel analog sampler. It has four sample sequencers, and each one owns a 16-entry result FIFO. A single trigger input, normally pulsed by a timer, can deposit one sample into several sequencers in the same cycle. A sequencer accepts that sample only when two things hold: it is switched on in the enable register, and its 4-bit event field selects the timer source (code 5). No converter is attached. The sample value is built from a 32-bit pseudo-random register, so software that reads the results as noise still gets values that vary.

Software uses a simple register port with write strobe, read strobe, address and data lanes. Read data is combinational from the address. A read strobe on a sequencer's pop address removes the oldest entry at the clock edge that ends the read. Each sequencer also has a status word, which shows its read pointer, write pointer, empty flag and full flag. Four interrupt lines report raw sequencer events, each gated by its own mask bit. Overflow and underflow are kept as sticky bits that software clears by writing ones.

Top module: `adc_seq_capture`

## Requirements
- R1: After reset every FIFO is empty, its status word reads 0x0000_0100, and the enable (0x00), raw (0x04), mask (0x08), error (0x10) and event (0x14) registers and irq_o all read zero. The noise register starts at zero.
- R2: Bit n of the enable register (0x00, bits 3:0) switches sequencer n on. Sequencer n takes its event code from bits 4n+3:4n of the event register (0x14). Only code 5 routes the trigger. A sequencer that is off, or that holds any other code, receives nothing.
- R3: In a cycle where trig_i is high, every routed sequencer receives one sample and sets raw bit n (0x04). The raw bit is set even when the sample is dropped.
- R4: The status word of sequencer n sits at 0x40+0x20n+0x0C. It holds the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12. All other bits read zero. Full means 16 entries are stored.
- R5: A read of 0x40+0x20n+0x08 returns the oldest stored sample and advances the read pointer. Samples come out in arrival order, and the pointers wrap modulo 16.
- R6: A sample that arrives while the FIFO is full is dropped and sets bit n of the error register (0x10). A pop while the FIFO is empty returns zero, moves no pointer and sets bit 4+n. Writing ones to 0x10 clears the matching bits. An event in the same cycle wins over the clear.
- R7: On each trigger cycle the noise register becomes noise*314159+1, modulo 2^32. The sample value is 0x200 plus bits 18:16 of the updated value.
- R8: irq_o[n] is raw bit n AND mask bit n, where the mask sits at 0x08 bits 3:0. A read of 0x0C returns raw AND mask.
- R9: Writing ones to 0x0C clears the matching raw bits. A trigger that sets a bit in the same cycle wins.
- R10: The input-mux register (0x40+0x20n) keeps only the bits in 0x3333_3333. The control register (0x40+0x20n+0x04) keeps all 32 bits. Neither changes the sample flow.
- R11: When a sample arrives and a pop happens in the same cycle, fullness and emptiness are judged before the pop. On a full FIFO the pop succeeds and the sample is dropped. On an empty FIFO the pop underflows and the sample is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Timer trigger, one sample per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on pop addresses) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 4 | Per-sequencer masked interrupt |

## Verification
The bench attacks four corner cases.

- Trigger routing: it mixes disabled sequencers with non-timer event codes. A wrong decode would fill a FIFO that should stay empty.
- FIFO boundaries: it drives FIFOs to exactly 16 entries and past that, then drains them across the pointer wrap. A design that compares pointers without flags would read a full FIFO as empty or corrupt the order.
- Same-cycle collisions: it collides a pop with a push on a full FIFO and on an empty FIFO, and collides a clear with a trigger. Getting the order wrong shows up as lost or extra entries, a missing overflow or underflow bit, or a raw bit that vanishes.
- Sample values: every popped value is compared against the noise sequence. A missed noise step, or a step taken on a cycle without a trigger, shifts every later sample.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned SEQ_N     = 4;
  localparam int unsigned EVT_W     = 4;
  localparam logic [3:0]  EVT_TIMER = 4'd5;

  localparam int unsigned A_ENABLE = 'h00;
  localparam int unsigned A_RAW    = 'h04;
  localparam int unsigned A_MASK   = 'h08;
  localparam int unsigned A_MIS    = 'h0C;
  localparam int unsigned A_ERR    = 'h10;
  localparam int unsigned A_EVT    = 'h14;

  localparam int unsigned SEQ_BLK_LSB = 5;   // 0x20 per sequencer
  localparam int unsigned SEQ_BLK0    = 2;   // first block at 0x40
  localparam logic [4:0]  OFS_MUX  = 5'h00;
  localparam logic [4:0]  OFS_CTL  = 5'h04;
  localparam logic [4:0]  OFS_POP  = 5'h08;
  localparam logic [4:0]  OFS_STAT = 5'h0C;

  localparam logic [31:0] MUX_KEEP  = 32'h3333_3333;
  localparam logic [31:0] NOISE_MUL = 32'd314159;
  localparam int unsigned SMP_BASE  = 'h200;
endpackage

// File: rtl/adc_noise_gen.sv
module adc_noise_gen #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [DATA_W-1:0] sample_o
);
  import adc_seq_pkg::*;

  logic [31:0] nz_q;
  logic [31:0] nz_nx;

  assign nz_nx    = nz_q * NOISE_MUL + 32'd1;
  assign sample_o = DATA_W'(SMP_BASE) + DATA_W'(nz_nx[18:16]);

  always_ff @(posedge clk) begin
    if (!rst_n)      nz_q <= '0;
    else if (step_i) nz_q <= nz_nx;
  end
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [31:0]       stat_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head, tail, head_nx, tail_nx;
  logic              empty, full, push_ok, pop_ok;

  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty;
  assign head_nx = head + PTR_W'(1);
  assign tail_nx = tail + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (push_ok) mem[head] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      if (push_ok) head <= head_nx;
      if (pop_ok)  tail <= tail_nx;
      case ({push_ok, pop_ok})
        2'b10: begin
          empty <= 1'b0;
          full  <= (head_nx == tail);
        end
        2'b01: begin
          full  <= 1'b0;
          empty <= (tail_nx == head);
        end
        default: ;
      endcase
    end
  end

  assign data_o = empty ? '0 : mem[tail];
  assign ovf_o  = push_i && full;
  assign unf_o  = pop_i && empty;
  assign stat_o = 32'(tail) | (32'(head) << 4) | (32'(empty) << 8) | (32'(full) << 12);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(empty && full)); // R4
  AST_FLAG_PTR_EQ: assert property (@(posedge clk) disable iff (!rst_n) (empty || full) |-> (head == tail)); // R4
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (full && push_i && !pop_i) |=> (full && $stable(head))); // R6
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (empty && pop_i && !push_i) |=> (empty && $stable(tail))); // R6
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_i,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [3:0]  irq_o
);
  import adc_seq_pkg::*;

  localparam int unsigned SEL_W = ADDR_W - SEQ_BLK_LSB;
  localparam int unsigned EVR_W = SEQ_N * EVT_W;

  logic [SEQ_N-1:0]  en_q, mask_q, raw_q, ovf_q, unf_q;
  logic [EVR_W-1:0]  evt_q;
  logic [SEQ_N-1:0]  hit, pop, ovf_ev, unf_ev, in_seq;
  logic [SEQ_N-1:0]  raw_clr, err_ovf_clr, err_unf_clr;
  logic [4:0]        ofs;
  logic [DATA_W-1:0] sample;
  logic [31:0]       seq_rd [SEQ_N];
  logic [31:0]       glob_rd;

  assign ofs = bus_addr[4:0];

  adc_noise_gen #(.DATA_W(DATA_W)) u_noise (
    .clk(clk), .rst_n(rst_n), .step_i(trig_i), .sample_o(sample)
  );

  for (genvar n = 0; n < SEQ_N; n++) begin : g_seq
    logic [31:0]       mux_q, ctl_q, stat;
    logic [DATA_W-1:0] head_data;

    assign in_seq[n] = (bus_addr[ADDR_W-1:SEQ_BLK_LSB] == SEL_W'(SEQ_BLK0 + n));
    assign hit[n]    = trig_i && en_q[n] && (evt_q[n*EVT_W +: EVT_W] == EVT_TIMER);
    assign pop[n]    = bus_rd && in_seq[n] && (ofs == OFS_POP);

    adc_seq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_i(hit[n]), .data_i(sample),
      .pop_i(pop[n]), .data_o(head_data),
      .stat_o(stat), .ovf_o(ovf_ev[n]), .unf_o(unf_ev[n])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mux_q <= '0;
        ctl_q <= '0;
      end else if (bus_wr && in_seq[n]) begin
        if (ofs == OFS_MUX) mux_q <= bus_wdata & MUX_KEEP;
        if (ofs == OFS_CTL) ctl_q <= bus_wdata;
      end
    end

    always_comb begin
      seq_rd[n] = '0;
      if (in_seq[n]) begin
        case (ofs)
          OFS_MUX:  seq_rd[n] = mux_q;
          OFS_CTL:  seq_rd[n] = ctl_q;
          OFS_POP:  seq_rd[n] = 32'(head_data);
          OFS_STAT: seq_rd[n] = stat;
          default:  seq_rd[n] = '0;
        endcase
      end
    end
  end

  assign raw_clr     = (bus_wr && bus_addr == ADDR_W'(A_MIS)) ? bus_wdata[SEQ_N-1:0] : '0;
  assign err_ovf_clr = (bus_wr && bus_addr == ADDR_W'(A_ERR)) ? bus_wdata[SEQ_N-1:0] : '0;
  assign err_unf_clr = (bus_wr && bus_addr == ADDR_W'(A_ERR)) ? bus_wdata[2*SEQ_N-1:SEQ_N] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      evt_q  <= '0;
      raw_q  <= '0;
      ovf_q  <= '0;
      unf_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~raw_clr) | hit;
      ovf_q <= (ovf_q & ~err_ovf_clr) | ovf_ev;
      unf_q <= (unf_q & ~err_unf_clr) | unf_ev;
      if (bus_wr && bus_addr == ADDR_W'(A_ENABLE)) en_q   <= bus_wdata[SEQ_N-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_MASK))   mask_q <= bus_wdata[SEQ_N-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_EVT))    evt_q  <= bus_wdata[EVR_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(A_ENABLE): glob_rd = 32'(en_q);
      ADDR_W'(A_RAW):    glob_rd = 32'(raw_q);
      ADDR_W'(A_MASK):   glob_rd = 32'(mask_q);
      ADDR_W'(A_MIS):    glob_rd = 32'(raw_q & mask_q);
      ADDR_W'(A_ERR):    glob_rd = 32'({unf_q, ovf_q});
      ADDR_W'(A_EVT):    glob_rd = 32'(evt_q);
      default:           glob_rd = '0;
    endcase
  end

  always_comb begin
    bus_rdata = glob_rd;
    for (int n = 0; n < SEQ_N; n++) bus_rdata = bus_rdata | seq_rd[n];
  end

  assign irq_o = raw_q & mask_q;

  AST_TRIG_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n) (hit != '0) |=> ((raw_q & $past(hit)) == $past(hit))); // R3
  AST_UNDERFLOW_STICKS: assert property (@(posedge clk) disable iff (!rst_n) (unf_ev != '0) |=> ((unf_q & $past(unf_ev)) == $past(unf_ev))); // R6
  AST_OVERFLOW_STICKS: assert property (@(posedge clk) disable iff (!rst_n) (ovf_ev != '0) |=> ((ovf_q & $past(ovf_ev)) == $past(ovf_ev))); // R6
endmodule

// File: tb/adc_seq_capture_bench.sv
`timescale 1ns/1ps
module adc_seq_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_i = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;

  always #4 clk = ~clk;

  adc_seq_capture u_adc_seq_capture (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int unsigned mq [4][$];
  int          mh [4];
  int          mt [4];
  bit [3:0]    m_en, m_mask, m_raw, m_ovf, m_unf;
  bit [15:0]   m_evt;
  bit [31:0]   m_mux [4];
  bit [31:0]   m_ctl [4];
  bit [31:0]   m_nz;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] model_read(bit [7:0] a);
    int i;
    if (a >= 8'h40 && a < 8'hC0) begin
      i = (int'(a) - 'h40) >> 5;
      case (a & 8'h1F)
        8'h00: return m_mux[i];
        8'h04: return m_ctl[i];
        8'h08: return (mq[i].size() == 0) ? 32'd0 : mq[i][0];
        8'h0C: return 32'(mt[i]) | (32'(mh[i]) << 4) |
                      ((mq[i].size() == 0) ? 32'h100 : 32'h0) |
                      ((mq[i].size() == 16) ? 32'h1000 : 32'h0);
        default: return 32'd0;
      endcase
    end
    case (a)
      8'h00: return 32'(m_en);
      8'h04: return 32'(m_raw);
      8'h08: return 32'(m_mask);
      8'h0C: return 32'(m_raw & m_mask);
      8'h10: return {24'd0, m_unf, m_ovf};
      8'h14: return 32'(m_evt);
      default: return 32'd0;
    endcase
  endfunction

  task automatic cyc(bit t, bit wr, bit rd, bit [7:0] a, bit [31:0] wd, string tag);
    bit [3:0] hits, ovf_e, unf_e, clr;
    bit [31:0] smp;
    int pi;
    trig_i = t; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    #1;
    if (rd) check(bus_rdata === model_read(a), tag, bus_rdata, model_read(a));
    hits = '0; ovf_e = '0; unf_e = '0; smp = 0;
    if (t) begin
      m_nz = m_nz * 32'd314159 + 32'd1;
      smp  = 32'h200 + ((m_nz >> 16) & 32'h7);
      for (int i = 0; i < 4; i++)
        if (m_en[i] && ((m_evt >> (4 * i)) & 16'hF) == 16'd5) hits[i] = 1'b1;
    end
    pi = -1;
    if (rd && a >= 8'h40 && a < 8'hC0 && (a & 8'h1F) == 8'h08) pi = (int'(a) - 'h40) >> 5;
    for (int i = 0; i < 4; i++) begin
      bit was_full, was_empty;
      was_full  = (mq[i].size() == 16);
      was_empty = (mq[i].size() == 0);
      if (pi == i) begin
        if (was_empty) unf_e[i] = 1'b1;
        else begin void'(mq[i].pop_front()); mt[i] = (mt[i] + 1) % 16; end
      end
      if (hits[i]) begin
        if (was_full) ovf_e[i] = 1'b1;
        else begin mq[i].push_back(smp); mh[i] = (mh[i] + 1) % 16; end
      end
    end
    clr = (wr && a == 8'h0C) ? wd[3:0] : 4'h0;
    m_raw = (m_raw & ~clr) | hits;
    clr = (wr && a == 8'h10) ? wd[3:0] : 4'h0;
    m_ovf = (m_ovf & ~clr) | ovf_e;
    clr = (wr && a == 8'h10) ? wd[7:4] : 4'h0;
    m_unf = (m_unf & ~clr) | unf_e;
    if (wr) begin
      if (a == 8'h00) m_en = wd[3:0];
      if (a == 8'h08) m_mask = wd[3:0];
      if (a == 8'h14) m_evt = wd[15:0];
      if (a >= 8'h40 && a < 8'hC0) begin
        if ((a & 8'h1F) == 8'h00) m_mux[(int'(a) - 'h40) >> 5] = wd & 32'h3333_3333;
        if ((a & 8'h1F) == 8'h04) m_ctl[(int'(a) - 'h40) >> 5] = wd;
      end
    end
    @(posedge clk);
    @(negedge clk);
    trig_i = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    #1;
    check(irq_o === (m_raw & m_mask), "R8 irq", 32'(irq_o), 32'(m_raw & m_mask));
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d, string tag); cyc(1'b0, 1'b1, 1'b0, a, d, tag); endtask
  task automatic rd(bit [7:0] a, string tag);               cyc(1'b0, 1'b0, 1'b1, a, 32'd0, tag); endtask
  task automatic trg(string tag);                           cyc(1'b1, 1'b0, 1'b0, 8'h00, 32'd0, tag); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mh[i] = 0; mt[i] = 0; m_mux[i] = 0; m_ctl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) rd(8'(8'h4C + 8'h20 * i), "R1 status");
    rd(8'h00, "R1 enable"); rd(8'h04, "R1 raw"); rd(8'h08, "R1 mask");
    rd(8'h10, "R1 err");    rd(8'h14, "R1 evt");
    // R10 mux/ctl
    wr(8'h40, 32'hFFFF_FFFF, "R10"); rd(8'h40, "R10 mux keep");
    wr(8'h84, 32'hDEAD_BEEF, "R10"); rd(8'h84, "R10 ctl");
    // R2 routing: seq0,1,3 timer, seq2 external; seq3 disabled
    wr(8'h14, 32'h0000_5455, "R2"); wr(8'h00, 32'h7, "R2");
    repeat (3) trg("R3");
    rd(8'h4C, "R4 seq0 status"); rd(8'h8C, "R2 seq2 untouched"); rd(8'hAC, "R2 seq3 disabled");
    rd(8'h04, "R3 raw bits");
    // R5/R7 pop order and values, then R6 underflow
    repeat (3) rd(8'h48, "R5 R7 pop seq0");
    rd(8'h48, "R6 empty pop zero"); rd(8'h10, "R6 underflow bit");
    wr(8'h10, 32'h10, "R6 clear"); rd(8'h10, "R6 cleared");
    // R8/R9 mask and clear
    wr(8'h08, 32'h1, "R8"); rd(8'h0C, "R8 masked");
    cyc(1'b1, 1'b1, 1'b0, 8'h0C, 32'hF, "R9 trig beats clear"); rd(8'h04, "R9 raw kept");
    wr(8'h0C, 32'h1, "R9 clear"); rd(8'h04, "R9 raw cleared");
    // fill seq1 (has 4) to full and beyond
    repeat (12) trg("R3 fill");
    rd(8'h6C, "R4 full status");
    trg("R6 overflow"); rd(8'h10, "R6 overflow bit"); rd(8'h6C, "R6 full unchanged");
    wr(8'h10, 32'hFF, "R6 clear all"); rd(8'h10, "R6 cleared");
    // R11 collisions
    cyc(1'b1, 1'b0, 1'b1, 8'h68, 32'd0, "R11 full pop+push");
    rd(8'h10, "R11 overflow on full"); rd(8'h6C, "R11 status");
    wr(8'h14, 32'h0000_5555, "R2"); wr(8'h00, 32'h4, "R2");
    cyc(1'b1, 1'b0, 1'b1, 8'h88, 32'd0, "R11 empty pop+push");
    rd(8'h10, "R11 underflow on empty"); rd(8'h8C, "R11 stored");
    rd(8'h88, "R5 seq2 pop");
    // drain seq1 across wrap
    for (int k = 0; k < 16; k++) rd(8'h68, "R5 drain wrap");
    rd(8'h6C, "R4 empty wrapped");
    wr(8'h08, 32'hF, "R8"); rd(8'h0C, "R8 all mask");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule